// File: doc/BRIEF.md
# Dual-Channel 8-bit PWM Timer

This block is an 8-bit counter with two compare channels, A and B. Each channel drives one waveform output. The counter advances only in cycles where the `tick` input is high, so an external divider sets the count rate. Typical divide factors are 1, 8, 64, 256 or 1024. Four counting schemes are available:

- free-running wrap;
- clear when the count equals compare A;
- single-slope PWM;
- dual-slope, phase-correct PWM.

A per-channel action code chooses whether the output toggles, clears or sets on a match, or stays off. In the PWM schemes, clear and set select the non-inverted and the inverted polarity.

Software reaches the block through one address/data port. A write takes effect on the clock edge. A read returns the selected register one cycle after the address is presented. Writes to the compare registers are staged in a buffer while a PWM scheme is active, and the buffer is copied to the comparator at TOP (count 255). In the non-PWM schemes the comparator takes the written value at once. Force strobes apply a channel's action to its output without touching the counter or any flag. Three sticky flags, for overflow and for each compare, are brought out as ports. Software clears them by writing ones.

Register map (addr): 0 control, 1 count, 2 compare A, 3 compare B, 4 force strobes, 5 flags.

Top module: `tmr8_pwm`

## Requirements
- R1: After a synchronous reset the following read as 0: control, count, compare A, compare B and flags. Both waveform outputs are low.
- R2: The counter changes only in cycles with `tick` high. In scheme 0 (control bits [1:0]=0) it counts up and wraps from 255 to 0. Writing count (addr 1) loads it directly.
- R3: In scheme 1 the counter returns to 0 on the tick after it equals compare A. With action code 1 (toggle), output A is a square wave of period 2*(A+1) ticks. No overflow flag occurs while A < 255.
- R4: Scheme 2 is single-slope PWM with a period of 256 ticks. Action code 2 holds the output high for C+1 ticks per period, where C is the channel's compare value, so C=255 is constant high. Code 3 gives the complement.
- R5: Scheme 3 is phase-correct PWM that counts 0 to 255 and back, with a period of 510 ticks. Code 2 clears on an up-count match and sets on a down-count match, giving 2*C high ticks per period. Code 3 gives the complement.
- R6: The overflow flag (flags bit 0) is set when the counter wraps from 255 in schemes 0, 1 and 2. In scheme 3 it is set at the bottom turnaround.
- R7: In schemes 2 and 3 a compare write is held in a buffer and reaches the comparator only at TOP. In schemes 0 and 1 it reaches the comparator at once. Reading back a compare register returns the last value written.
- R8: Writing 1 to force bit 0 or 1 (addr 4) applies channel A's or channel B's action code to that output. It sets no flag and leaves the count unchanged, even in scheme 1.
- R9: A change of action code does not alter the output level until the next match or force on that channel.
- R10: Writing 1 to a flags bit clears that flag. A new event in the same cycle keeps it set.
- R11: Action code 0 holds the channel output low.
- R12: A compare flag (flags bit 1 for A, bit 2 for B) is set by a tick in which the count equals the channel's active compare value.

Control register layout: bits [1:0] select the scheme, bits [3:2] hold the action code of A, and bits [5:4] hold the action code of B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the external divider |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both write and read |
| wdata | input | W | Write data |
| rdata | output | W | Registered read data for `addr` |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| flag_ovf | output | 1 | Sticky overflow flag |
| flag_cmpa | output | 1 | Sticky compare A flag |
| flag_cmpb | output | 1 | Sticky compare B flag |

## Verification
The assertions assume three things about the inputs:

- `tick`, `wr_en` and `addr` carry known values once reset is released.
- A count write and a tick in the same cycle let the write win.
- The hold checks only apply in cycles without a tick, a load or a force.

The stimulus changes inputs only on the falling edge. It holds `tick` low around every register access that is meant to freeze the count, so each window of observed ticks is exactly known. Free-running PWM measurements are taken only after at least two full periods have passed, so every buffered compare value is already in the comparator.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    WM_NORMAL = 2'd0,
    WM_CTC    = 2'd1,
    WM_FAST   = 2'd2,
    WM_PHASE  = 2'd3
  } wmode_t;

  typedef enum logic [1:0] {
    OC_OFF    = 2'd0,
    OC_TOGGLE = 2'd1,
    OC_CLEAR  = 2'd2,
    OC_SET    = 2'd3
  } ocact_t;

  localparam int NCH    = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FORCE = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;
endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  wmode_t       mode,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] top_ctc,
  output logic [W-1:0] cnt,
  output logic         step,
  output logic         top_ev,
  output logic         ovf_ev,
  output logic         up_cls
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic dir_up;

  assign step   = tick & ~ld;
  assign top_ev = step & (cnt == MAXV);
  assign ovf_ev = step & ((mode == WM_PHASE) ? (~dir_up & (cnt == '0))
                                             : (cnt == MAXV));
  // Direction the count takes after this tick (classifies phase-correct matches)
  assign up_cls = dir_up ? (cnt != MAXV) : (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (tick) begin
      case (mode)
        WM_CTC:   cnt <= (cnt == top_ctc) ? '0 : cnt + 1'b1;
        WM_PHASE: begin
          if (dir_up) begin
            if (cnt == MAXV) begin
              dir_up <= 1'b0;
              cnt    <= cnt - 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            if (cnt == '0) begin
              dir_up <= 1'b1;
              cnt    <= cnt + 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default:  cnt <= cnt + 1'b1;
      endcase
    end
  end

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> $stable(cnt));

  a_r3_ctc_returns_zero: assert property (@(posedge clk) disable iff (rst)
    (mode == WM_CTC && step && cnt == top_ctc) |=> (cnt == '0));

  a_r5_turn_at_top: assert property (@(posedge clk) disable iff (rst)
    (mode == WM_PHASE && step && dir_up && cnt == MAXV) |=> (!dir_up && cnt == MAXV - 1'b1));
endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [W-1:0]             wdata,
  input  logic [W-1:0]             cnt,
  input  logic                     top_ev,
  input  logic                     ovf_ev,
  input  logic [NCH-1:0]           match,
  output wmode_t                   mode,
  output logic [NCH-1:0][1:0]      code,
  output logic [NCH-1:0][W-1:0]    cmp_act,
  output logic                     cnt_ld,
  output logic [NCH-1:0]           force_s,
  output logic [W-1:0]             rdata,
  output logic                     flag_ovf,
  output logic [NCH-1:0]           flag_cmp
);
  localparam int CTRL_W = 2 + 2 * NCH;

  logic [CTRL_W-1:0]         ctrl;
  logic [NCH-1:0][W-1:0]     cmp_buf;
  logic                      pwm;
  logic                      flg_clr;

  assign mode    = wmode_t'(ctrl[1:0]);
  assign pwm     = ctrl[1];
  assign cnt_ld  = wr_en & (addr == A_COUNT);
  assign flg_clr = wr_en & (addr == A_FLAGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en && addr == A_CTRL) begin
      ctrl <= wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_ovf <= 1'b0;
    end else begin
      flag_ovf <= (flag_ovf & ~(flg_clr & wdata[0])) | ovf_ev;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic wr_c;
    assign wr_c        = wr_en & (addr == A_CMPA + ADDR_W'(ch));
    assign code[ch]    = ctrl[2 + 2*ch +: 2];
    assign force_s[ch] = wr_en & (addr == A_FORCE) & wdata[ch];

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_buf[ch] <= '0;
        cmp_act[ch] <= '0;
      end else begin
        if (wr_c) cmp_buf[ch] <= wdata;
        if (wr_c && !pwm) cmp_act[ch] <= wdata;
        else if (pwm && top_ev) cmp_act[ch] <= cmp_buf[ch];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_cmp[ch] <= 1'b0;
      end else begin
        flag_cmp[ch] <= (flag_cmp[ch] & ~(flg_clr & wdata[1+ch])) | match[ch];
      end
    end

    a_r7_buffer_hold: assert property (@(posedge clk) disable iff (rst)
      (pwm && wr_c && !top_ev) |=> $stable(cmp_act[ch]));

    a_r12_match_flag: assert property (@(posedge clk) disable iff (rst)
      match[ch] |=> flag_cmp[ch]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_CTRL:  rdata <= W'(ctrl);
        A_COUNT: rdata <= cnt;
        A_CMPA:  rdata <= cmp_buf[0];
        A_CMPB:  rdata <= cmp_buf[1];
        A_FLAGS: rdata <= W'({flag_cmp, flag_ovf});
        default: rdata <= '0;
      endcase
    end
  end

  a_r10_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> flag_ovf);
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  wmode_t       mode,
  input  logic [1:0]   code,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] cnt,
  input  logic         step,
  input  logic         top_ev,
  input  logic         up_cls,
  input  logic         force_s,
  output logic         match,
  output logic         wave
);
  ocact_t act;
  logic   oc, oc_n;

  assign act   = ocact_t'(code);
  assign match = step & (cnt == cmp);

  always_comb begin
    oc_n = oc;
    if (force_s) begin
      case (act)
        OC_TOGGLE: oc_n = ~oc;
        OC_CLEAR:  oc_n = 1'b0;
        OC_SET:    oc_n = 1'b1;
        default:   oc_n = oc;
      endcase
    end else begin
      if (match) begin
        case (act)
          OC_TOGGLE: oc_n = ~oc;
          OC_CLEAR:  oc_n = (mode == WM_PHASE) ? ~up_cls : 1'b0;
          OC_SET:    oc_n = (mode == WM_PHASE) ? up_cls  : 1'b1;
          default:   oc_n = oc;
        endcase
      end
      if (mode == WM_FAST && top_ev) begin
        if (act == OC_CLEAR)    oc_n = 1'b1;
        else if (act == OC_SET) oc_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oc   <= 1'b0;
      wave <= 1'b0;
    end else begin
      oc   <= oc_n;
      wave <= (act != OC_OFF) & oc_n;
    end
  end

  a_r9_level_held: assert property (@(posedge clk) disable iff (rst)
    (!match && !force_s && !top_ev) |=> $stable(oc));

  a_r11_off_is_low: assert property (@(posedge clk) disable iff (rst)
    (code == 2'd0) |=> !wave);
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         wave_a,
  output logic         wave_b,
  output logic         flag_ovf,
  output logic         flag_cmpa,
  output logic         flag_cmpb
);
  wmode_t                mode;
  logic [NCH-1:0][1:0]   code;
  logic [NCH-1:0][W-1:0] cmp_act;
  logic [NCH-1:0]        force_s, match, flag_cmp, wave_v;
  logic [W-1:0]          cnt;
  logic                  cnt_ld, step, top_ev, ovf_ev, up_cls;

  tmr8_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .top_ev(top_ev), .ovf_ev(ovf_ev), .match(match),
    .mode(mode), .code(code), .cmp_act(cmp_act), .cnt_ld(cnt_ld),
    .force_s(force_s), .rdata(rdata), .flag_ovf(flag_ovf), .flag_cmp(flag_cmp)
  );

  tmr8_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .ld(cnt_ld),
    .ld_val(wdata), .top_ctc(cmp_act[0]), .cnt(cnt), .step(step),
    .top_ev(top_ev), .ovf_ev(ovf_ev), .up_cls(up_cls)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_wave
    tmr8_wave #(.W(W)) u_wave (
      .clk(clk), .rst(rst), .mode(mode), .code(code[ch]), .cmp(cmp_act[ch]),
      .cnt(cnt), .step(step), .top_ev(top_ev), .up_cls(up_cls),
      .force_s(force_s[ch]), .match(match[ch]), .wave(wave_v[ch])
    );
  end

  assign wave_a    = wave_v[0];
  assign wave_b    = wave_v[1];
  assign flag_cmpa = flag_cmp[0];
  assign flag_cmpb = flag_cmp[1];

  a_r8_force_sets_no_flag: assert property (@(posedge clk) disable iff (rst)
    (force_s[0] && !tick) |=> !$rose(flag_cmpa));

  a_r8_force_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (force_s[0] && !tick && !cnt_ld) |=> $stable(cnt));
endmodule

// File: tb/tmr8_pwm_bench.sv
module tmr8_pwm_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         wave_a, wave_b, flag_ovf, flag_cmpa, flag_cmpb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr8_pwm #(.W(W)) u_tmr8_pwm (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wave_a(wave_a), .wave_b(wave_b),
    .flag_ovf(flag_ovf), .flag_cmpa(flag_cmpa), .flag_cmpb(flag_cmpb)
  );

  // Rows: ctrl, cmpA, cmpB, period, high ticks A, high ticks B
  localparam int TV [6][6] = '{
    '{8'h3A,   0, 100, 256,   1, 155},   // R4 fast: A code2, B code3
    '{8'h2A, 255, 100, 256, 256, 101},   // R4 fast: constant high at 255
    '{8'h0E, 255,  50, 256,   0,   0},   // R4/R11 A code3, B off
    '{8'h3B,  60,  60, 510, 120, 390},   // R5 phase: A code2, B code3
    '{8'h2B,   0, 255, 510,   0, 510},   // R5 phase extremes
    '{8'h2F, 200,   1, 510, 110,   2}    // R5 A code3, B code2
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = int'(rdata);
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    wrap_up();
  end

  initial begin
    int v, ha, hb;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 count", v, 0);
    rd(3'd2, v); chk("R1 cmpA", v, 0);
    rd(3'd3, v); chk("R1 cmpB", v, 0);
    rd(3'd5, v); chk("R1 flags", v, 0);
    chk("R1 waves", {wave_a, wave_b}, 0);

    // R2 hold without tick, then wrap with overflow (R6)
    repeat (10) @(negedge clk);
    rd(3'd1, v); chk("R2 idle count", v, 0);
    wr(3'd1, 8'd250);
    run_ticks(10);
    rd(3'd1, v); chk("R2 wrapped count", v, 4);
    rd(3'd5, v); chk("R6 overflow at wrap", v & 1, 1);

    // R10 clear by writing ones
    wr(3'd5, 8'h07);
    rd(3'd5, v); chk("R10 flags cleared", v, 0);

    // R12 compare flag timing
    wr(3'd2, 8'd7);
    wr(3'd3, 8'd200);
    wr(3'd1, 8'd0);
    run_ticks(7);
    rd(3'd5, v); chk("R12 no match yet", v, 0);
    run_ticks(1);
    rd(3'd5, v); chk("R12 match A only", v, 2);

    // R3 CTC toggle square wave
    wr(3'd0, 8'h05);
    wr(3'd2, 8'd3);
    wr(3'd1, 8'd0);
    wr(3'd5, 8'h07);
    @(negedge clk);
    tick = 1'b1;
    ha = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      ha += int'(wave_a);
    end
    tick = 1'b0;
    chk("R3 square wave duty", ha, 40);
    rd(3'd1, v); chk("R3 count bounded", int'(v <= 3), 1);
    rd(3'd5, v); chk("R3 no overflow", v & 1, 0);
    chk("R12 ctc match flag", (v >> 1) & 1, 1);

    // R4/R5/R11 vector table
    tick = 1'b1;
    for (int i = 0; i < 6; i++) begin
      wr(3'd0, 8'(TV[i][0]));
      wr(3'd2, 8'(TV[i][1]));
      wr(3'd3, 8'(TV[i][2]));
      repeat (1100) @(negedge clk);
      ha = 0; hb = 0;
      for (int k = 0; k < TV[i][3]; k++) begin
        @(negedge clk);
        ha += int'(wave_a);
        hb += int'(wave_b);
      end
      chk(TV[i][3] == 256 ? "R4 channel A duty" : "R5 channel A duty", ha, TV[i][4]);
      chk(TV[i][3] == 256 ? "R4 channel B duty" : "R5 channel B duty", hb, TV[i][5]);
    end
    tick = 1'b0;

    // R7 buffering in PWM, immediate in normal
    wr(3'd0, 8'h0A);
    wr(3'd2, 8'd100);
    wr(3'd1, 8'd250);
    run_ticks(10);
    wr(3'd1, 8'd10);
    wr(3'd2, 8'd20);
    rd(3'd2, v); chk("R7 readback of buffer", v, 20);
    wr(3'd5, 8'h07);
    run_ticks(20);
    rd(3'd5, v); chk("R7 buffered value not active", (v >> 1) & 1, 0);
    wr(3'd0, 8'h08);
    wr(3'd2, 8'd40);
    wr(3'd1, 8'd30);
    wr(3'd5, 8'h07);
    run_ticks(11);
    rd(3'd5, v); chk("R7 immediate in normal", (v >> 1) & 1, 1);
    wr(3'd0, 8'h0A);
    wr(3'd2, 8'd5);
    wr(3'd1, 8'd250);
    wr(3'd5, 8'h07);
    run_ticks(6);
    rd(3'd5, v); chk("R7 old value until TOP", (v >> 1) & 1, 0);
    run_ticks(6);
    rd(3'd5, v); chk("R7 loaded at TOP", (v >> 1) & 1, 1);

    // R8 force strobes
    wr(3'd0, 8'h0C);
    wr(3'd1, 8'd77);
    wr(3'd5, 8'h07);
    wr(3'd4, 8'h01);
    chk("R8 force set", int'(wave_a), 1);
    rd(3'd5, v); chk("R8 no flag", v, 0);
    rd(3'd1, v); chk("R8 count kept", v, 77);
    wr(3'd0, 8'h05);
    wr(3'd2, 8'd77);
    wr(3'd4, 8'h01);
    chk("R8 ctc force toggle", int'(wave_a), 0);
    rd(3'd1, v); chk("R8 ctc count kept", v, 77);
    rd(3'd5, v); chk("R8 ctc no flag", v, 0);

    // R9 action change waits for a match
    wr(3'd0, 8'h0C);
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h08);
    repeat (3) @(negedge clk);
    chk("R9 level kept after code change", int'(wave_a), 1);
    wr(3'd1, 8'd5);
    wr(3'd2, 8'd6);
    run_ticks(1);
    chk("R9 kept before match", int'(wave_a), 1);
    run_ticks(1);
    chk("R9 new action at match", int'(wave_a), 0);

    // R6 overflow at bottom in phase mode, at wrap in fast mode
    wr(3'd0, 8'h03);
    wr(3'd1, 8'd255);
    wr(3'd5, 8'h07);
    run_ticks(255);
    rd(3'd5, v); chk("R6 phase no flag before bottom", v & 1, 0);
    rd(3'd1, v); chk("R6 phase reached bottom", v, 0);
    run_ticks(1);
    rd(3'd5, v); chk("R6 phase flag at bottom", v & 1, 1);
    rd(3'd1, v); chk("R6 phase turned up", v, 1);
    wr(3'd0, 8'h02);
    wr(3'd1, 8'd254);
    wr(3'd5, 8'h07);
    run_ticks(1);
    rd(3'd5, v); chk("R6 fast no flag at 254", v & 1, 0);
    run_ticks(1);
    rd(3'd5, v); chk("R6 fast flag at wrap", v & 1, 1);
    rd(3'd1, v); chk("R6 fast wrapped", v, 0);

    wrap_up();
  end
endmodule